// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit

The block drives up to eight output pins from one free-running counter. Each channel holds a compare value. When the counter reaches that value, the channel changes its pin according to a two-bit action code and raises its own flag. Software can also fire a channel's action directly through a force register. A forced action behaves like a match on the pin but leaves the flag alone.

Channel 7 has two extra roles. It has a mask byte and a data byte. When channel 7 fires, every pin whose mask bit is set takes the matching data bit. This overrides whatever that pin's own channel would have done in the same cycle. A pin is driven only when its channel is selected for compare, its disconnect bit is clear, and it has something to drive: a non-zero action or a channel-7 mask bit.

All configuration goes through a simple register write port. A combinational read port returns register contents.

Top module: `occ_unit`

## Requirements
- R1: The counter is CW bits wide and adds one on every clock, wrapping from all-ones to zero. A write to address 0x04 loads the written value at that edge. Reading 0x04 returns the current count.
- R2: Bit x of the select register (0x00) enables channel x. The action codes are held at 0x05 (channels 0-3) and 0x06 (channels 4-7), with channel n of a register in bits 2n+1:2n. The codes are 00 = leave pin, 01 = toggle, 10 = drive 0, 11 = drive 1. When the counter equals the compare register at 0x10+x, the pin takes the action at the next clock edge and not before.
- R3: A match sets bit x of the flag register (0x07) at the same edge the pin changes. Writing 1 to a flag bit clears it. A match wins over a clear at the same edge.
- R4: Writing 1 to bit x of the force register (0x01) applies channel x's action at the edge of that write, without any match, and leaves flag x unchanged.
- R5: A force and a match on one channel at the same edge apply the action once, and the flag stays clear.
- R6: Reading the force register always returns zero.
- R7: When channel 7 fires, by match or by force, every pin whose bit is set in the mask register (0x02) takes the matching bit of the data register (0x03). This overrides that pin's own channel action, including channel 7's own action on pin 7.
- R8: pin_oe[x] is 1 only when all of these hold:
  - select bit x is 1;
  - disconnect bit x (0x08) is 0;
  - either the action code of channel x is non-zero or mask bit x is set.

  pin_out[x] shows the pin state when pin_oe[x] is 1, and is 0 otherwise.
- R9: After reset, all registers, pin states and flags are zero. The mask and data registers read back what was written.
- R10: A channel whose select bit is 0 ignores both matches and forces. Its pin state and flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | CW | Register read data (combinational) |
| pin_out | output | NCH | Channel pin levels |
| pin_oe | output | NCH | Channel pin drive enables |
| flags | output | NCH | Per-channel match flags |

## Verification
The bench builds the unit with NCH = 8 and CW = 8. Because the counter is only eight bits wide, any compare value can be reached a fixed three cycles after loading the counter, so match timing is known exactly. This allows a full sweep: every channel is run with every action code, and the pin and flag are checked in the cycle before the match edge and the cycle after it. The small counter also makes it practical to place a force write or a flag-clear write on the exact edge of a match, and to line up matches on channels 0, 1 and 7 in one cycle to show the channel-7 override and the disconnect gating.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

    localparam int ADDR_W     = 5;
    localparam int A_SEL      = 0;
    localparam int A_FORCE    = 1;
    localparam int A_MASK     = 2;
    localparam int A_DATA     = 3;
    localparam int A_CNT      = 4;
    localparam int A_ACT_BASE = 5;
    localparam int A_FLAG     = 7;
    localparam int A_DISC     = 8;
    localparam int A_CMP_BASE = 16;

endpackage

// File: rtl/occ_regs.sv
module occ_regs
    import occ_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [NCH-1:0]          flag_set,
    output logic [CW-1:0]           rd_data,
    output logic [CW-1:0]           cnt_q,
    output logic [NCH-1:0]          sel_q,
    output logic [NCH-1:0]          disc_q,
    output logic [NCH-1:0]          mask_q,
    output logic [NCH-1:0]          data_q,
    output logic [NCH-1:0]          force_vec,
    output logic [NCH-1:0]          flag_q,
    output logic [NCH-1:0][1:0]     act_q,
    output logic [NCH-1:0][CW-1:0]  cmp_q
);
    localparam int NACT = (NCH + 3) / 4;

    logic [NCH-1:0] flag_clr;

    // one-cycle strobes straight from the write port
    assign force_vec = (wr_en && wr_addr == ADDR_W'(A_FORCE)) ? wr_data[NCH-1:0] : '0;
    assign flag_clr  = (wr_en && wr_addr == ADDR_W'(A_FLAG))  ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sel_q  <= '0;
            disc_q <= '0;
            mask_q <= '0;
            data_q <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(A_CNT)) cnt_q <= wr_data;
            else                                    cnt_q <= cnt_q + 1'b1;
            if (wr_en && wr_addr == ADDR_W'(A_SEL))  sel_q  <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_DISC)) disc_q <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_MASK)) mask_q <= wr_data[NCH-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_DATA)) data_q <= wr_data[NCH-1:0];
            // a match in the same cycle outranks a software clear
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chreg
        localparam int CMP_A = A_CMP_BASE + ch;
        localparam int ACT_A = A_ACT_BASE + ch / 4;
        localparam int ACT_S = 2 * (ch % 4);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[ch] <= '0;
                act_q[ch] <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(CMP_A)) cmp_q[ch] <= wr_data;
                if (wr_en && wr_addr == ADDR_W'(ACT_A)) act_q[ch] <= wr_data[ACT_S +: 2];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_SEL))  rd_data = CW'(sel_q);
        if (rd_addr == ADDR_W'(A_MASK)) rd_data = CW'(mask_q);
        if (rd_addr == ADDR_W'(A_DATA)) rd_data = CW'(data_q);
        if (rd_addr == ADDR_W'(A_CNT))  rd_data = cnt_q;
        if (rd_addr == ADDR_W'(A_FLAG)) rd_data = CW'(flag_q);
        if (rd_addr == ADDR_W'(A_DISC)) rd_data = CW'(disc_q);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(A_CMP_BASE + i)) rd_data = cmp_q[i];
        end
        for (int k = 0; k < NACT; k++) begin
            if (rd_addr == ADDR_W'(A_ACT_BASE + k)) begin
                for (int j = 0; j < 4; j++) begin
                    if (4 * k + j < NCH) rd_data[2*j +: 2] = act_q[4*k + j];
                end
            end
        end
    end

endmodule

// File: rtl/occ_channel.sv
module occ_channel
    import occ_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          sel,
    input  logic          force_bit,
    input  logic [1:0]    act,
    input  logic          pin_cur,
    output logic          fire,
    output logic          flag_set,
    output logic          pin_nxt
);
    logic hit;

    assign hit      = sel && (cnt == cmp);
    assign fire     = sel && (hit || force_bit);
    assign flag_set = hit && !force_bit;

    always_comb begin
        unique case (oc_act_e'(act))
            ACT_HOLD:   pin_nxt = pin_cur;
            ACT_TOGGLE: pin_nxt = !pin_cur;
            ACT_LOW:    pin_nxt = 1'b0;
            ACT_HIGH:   pin_nxt = 1'b1;
        endcase
    end

endmodule

// File: rtl/occ_pinmux.sv
module occ_pinmux #(
    parameter int NCH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      fire_vec,
    input  logic [NCH-1:0]      act_nxt,
    input  logic [NCH-1:0]      mask,
    input  logic [NCH-1:0]      data,
    input  logic [NCH-1:0]      sel,
    input  logic [NCH-1:0]      disc,
    input  logic [NCH-1:0][1:0] act,
    output logic [NCH-1:0]      pin_q,
    output logic [NCH-1:0]      pin_oe,
    output logic [NCH-1:0]      pin_out
);
    localparam int MASTER = NCH - 1;

    logic master_fire;
    assign master_fire = fire_vec[MASTER];

    for (genvar x = 0; x < NCH; x++) begin : g_pin
        logic nxt;
        always_comb begin
            if (master_fire && mask[x]) nxt = data[x];
            else if (fire_vec[x])       nxt = act_nxt[x];
            else                        nxt = pin_q[x];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pin_q[x] <= 1'b0;
            else        pin_q[x] <= nxt;
        end

        assign pin_oe[x]  = sel[x] && !disc[x] && ((act[x] != 2'b00) || mask[x]);
        assign pin_out[x] = pin_oe[x] && pin_q[x];
    end

endmodule

// File: rtl/occ_unit.sv
module occ_unit
    import occ_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe,
    output logic [NCH-1:0]    flags
);
    logic [CW-1:0]           cnt_q;
    logic [NCH-1:0]          sel_q, disc_q, mask_q, data_q, force_vec;
    logic [NCH-1:0]          fire_vec, hit_flag, act_nxt, pin_q;
    logic [NCH-1:0][1:0]     act_q;
    logic [NCH-1:0][CW-1:0]  cmp_q;

    occ_regs #(.NCH(NCH), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .flag_set(hit_flag),
        .rd_data(rd_data), .cnt_q(cnt_q), .sel_q(sel_q), .disc_q(disc_q),
        .mask_q(mask_q), .data_q(data_q), .force_vec(force_vec),
        .flag_q(flags), .act_q(act_q), .cmp_q(cmp_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        occ_channel #(.CW(CW)) u_ch (
            .cnt(cnt_q), .cmp(cmp_q[ch]), .sel(sel_q[ch]),
            .force_bit(force_vec[ch]), .act(act_q[ch]), .pin_cur(pin_q[ch]),
            .fire(fire_vec[ch]), .flag_set(hit_flag[ch]), .pin_nxt(act_nxt[ch])
        );
    end

    occ_pinmux #(.NCH(NCH)) u_mux (
        .clk(clk), .rst_n(rst_n), .fire_vec(fire_vec), .act_nxt(act_nxt),
        .mask(mask_q), .data(data_q), .sel(sel_q), .disc(disc_q), .act(act_q),
        .pin_q(pin_q), .pin_oe(pin_oe), .pin_out(pin_out)
    );

endmodule

// File: rtl/occ_unit_chk.sv
module occ_unit_chk
    import occ_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CW-1:0]     rd_data,
    input logic [NCH-1:0]    pin_out,
    input logic [NCH-1:0]    pin_oe,
    input logic [NCH-1:0]    flags,
    input logic [NCH-1:0]    sel_q,
    input logic [NCH-1:0]    disc_q,
    input logic [NCH-1:0]    mask_q,
    input logic [NCH-1:0]    data_q,
    input logic [NCH-1:0]    force_vec,
    input logic [NCH-1:0]    fire_vec,
    input logic [NCH-1:0]    hit_flag,
    input logic [NCH-1:0]    pin_q
);
    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_flag) |=> ((flags & $past(hit_flag)) == $past(hit_flag)));

    assert_force_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(force_vec & ~flags)) |=> ((flags & $past(force_vec & ~flags)) == '0));

    assert_force_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(A_FORCE)) |-> (rd_data == '0));

    assert_master_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_vec[NCH-1] |=> (((pin_q ^ $past(data_q)) & $past(mask_q)) == '0));

    assert_oe_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & (~sel_q | disc_q)) == '0) && ((pin_out & ~pin_oe) == '0));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '0 && data_q == '0 && flags == '0 && pin_q == '0));

endmodule

bind occ_unit occ_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_out(pin_out), .pin_oe(pin_oe), .flags(flags), .sel_q(sel_q),
    .disc_q(disc_q), .mask_q(mask_q), .data_q(data_q), .force_vec(force_vec),
    .fire_vec(fire_vec), .hit_flag(hit_flag), .pin_q(pin_q)
);

// File: tb/occ_unit_bench.sv
module occ_unit_bench;
    import occ_pkg::*;

    localparam int NCH = 8;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [CW-1:0]     wr_data = '0;
    logic [CW-1:0]     rd_data;
    logic [NCH-1:0]    pin_out, pin_oe, flags;

    always #5 clk = ~clk;

    occ_unit #(.NCH(NCH), .CW(CW)) u_occ_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_out(pin_out), .pin_oe(pin_oe), .flags(flags)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench-side model
    logic [NCH-1:0] ep = '0, b_sel = '0, b_disc = '0, b_mask = '0, b_data = '0;
    logic [1:0]     b_act [NCH];

    function automatic logic apply_act(input logic [1:0] code, input logic cur);
        case (code)
            2'b00:   return cur;
            2'b01:   return !cur;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [NCH-1:0] exp_oe();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++)
            r[i] = b_sel[i] & ~b_disc[i] & ((b_act[i] != 2'b00) | b_mask[i]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, want);
        end
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        wr_addr = ADDR_W'(a);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output logic [CW-1:0] v);
        rd_addr = ADDR_W'(a);
        #1;
        v = rd_data;
    endtask

    task automatic put_acts();
        for (int k = 0; k < 2; k++) begin
            logic [CW-1:0] w = '0;
            for (int j = 0; j < 4; j++) w[2*j +: 2] = b_act[4*k + j];
            wr(A_ACT_BASE + k, w);
        end
    endtask

    task automatic set_sel(input logic [NCH-1:0] m);
        b_sel = m;
        wr(A_SEL, m);
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pin_out"}, 32'(pin_out), 32'(ep & exp_oe()));
        check({tag, " pin_oe"},  32'(pin_oe),  32'(exp_oe()));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [CW-1:0] v;
        logic [CW-1:0] c;
        for (int i = 0; i < NCH; i++) b_act[i] = 2'b00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 reset pins", 32'(pin_out), 0);
        check("R9 reset oe", 32'(pin_oe), 0);
        check("R9 reset flags", 32'(flags), 0);
        rd(A_MASK, v); check("R9 reset mask", 32'(v), 0);
        rd(A_DATA, v); check("R9 reset data", 32'(v), 0);

        // R1 counter load, increment, wrap
        wr(A_CNT, 8'h40);
        rd(A_CNT, v); check("R1 load", 32'(v), 32'h40);
        @(negedge clk);
        rd(A_CNT, v); check("R1 increment", 32'(v), 32'h41);
        wr(A_CNT, 8'hFF);
        rd(A_CNT, v); check("R1 load top", 32'(v), 32'hFF);
        @(negedge clk);
        rd(A_CNT, v); check("R1 wrap", 32'(v), 32'h00);

        // R2 / R3 sweep: every channel with every action code
        for (int ch = 0; ch < NCH; ch++) begin
            for (int a = 0; a < 4; a++) begin
                c = 8'(ch * 37 + a * 11 + 20);
                set_sel('0);
                wr(A_CMP_BASE + ch, c);
                b_act[ch] = 2'(a);
                put_acts();
                wr(A_CNT, c + 8'd64);
                set_sel(NCH'(1) << ch);
                wr(A_CNT, c - 8'd3);
                repeat (3) @(negedge clk);
                check_pins("R2 before match edge");
                @(negedge clk);
                ep[ch] = apply_act(2'(a), ep[ch]);
                check_pins("R2 after match edge");
                check("R3 flag set", 32'(flags), 32'(NCH'(1) << ch));
                wr(A_FLAG, NCH'(1) << ch);
                check("R3 flag cleared", 32'(flags), 0);
            end
        end

        // R3 match beats a same-edge clear
        c = 8'h33;
        set_sel('0);
        wr(A_CMP_BASE + 2, c);
        wr(A_CNT, c + 8'd64);
        set_sel(NCH'(1) << 2);
        wr(A_CNT, c - 8'd3);
        repeat (3) @(negedge clk);
        wr(A_FLAG, NCH'(1) << 2);
        ep[2] = apply_act(b_act[2], ep[2]);
        check("R3 set wins over clear", 32'(flags), 32'(NCH'(1) << 2));
        wr(A_FLAG, '1);

        // R4 / R6 forced action on every channel, toggle code
        for (int i = 0; i < NCH; i++) b_act[i] = 2'b01;
        put_acts();
        for (int ch = 0; ch < NCH; ch++) begin
            set_sel('0);
            rd(A_CMP_BASE + ch, v);
            wr(A_CNT, v + 8'd100);
            set_sel(NCH'(1) << ch);
            wr(A_FORCE, NCH'(1) << ch);
            ep[ch] = !ep[ch];
            check_pins("R4 forced toggle");
            check("R4 force leaves flag", 32'(flags), 0);
        end
        rd(A_FORCE, v); check("R6 force reads zero", 32'(v), 0);

        // R10 unselected channel ignores force
        set_sel('0);
        wr(A_FORCE, NCH'(1) << 3);
        set_sel(NCH'(1) << 3);
        check_pins("R10 force ignored");
        check("R10 no flag", 32'(flags), 0);

        // R5 force and match on the same edge
        c = 8'h5A;
        set_sel('0);
        wr(A_CMP_BASE + 5, c);
        wr(A_CNT, c + 8'd64);
        set_sel(NCH'(1) << 5);
        wr(A_CNT, c - 8'd3);
        repeat (3) @(negedge clk);
        wr(A_FORCE, NCH'(1) << 5);
        ep[5] = !ep[5];
        check_pins("R5 single action");
        check("R5 flag clear", 32'(flags), 0);

        // R7 channel 7 overrides masked pins
        c = 8'h90;
        set_sel('0);
        b_act[0] = 2'b11; b_act[1] = 2'b11; b_act[2] = 2'b00; b_act[7] = 2'b01;
        put_acts();
        wr(A_CMP_BASE + 0, c);
        wr(A_CMP_BASE + 1, c);
        wr(A_CMP_BASE + 7, c);
        b_mask = 8'h85; wr(A_MASK, b_mask);
        b_data = 8'h84; wr(A_DATA, b_data);
        wr(A_CNT, c + 8'd64);
        set_sel(8'h87);
        wr(A_FORCE, 8'h01);
        ep[0] = 1'b1;
        check_pins("R7 setup force");
        wr(A_CNT, c - 8'd3);
        repeat (4) @(negedge clk);
        ep[0] = b_data[0];
        ep[1] = 1'b1;
        ep[2] = b_data[2];
        ep[7] = b_data[7];
        check_pins("R7 match override");
        check("R7 flags", 32'(flags), 32'h83);
        wr(A_FLAG, '1);
        b_data = 8'h01; wr(A_DATA, b_data);
        wr(A_FORCE, 8'h80);
        ep[0] = 1'b1; ep[2] = 1'b0; ep[7] = 1'b0;
        check_pins("R7 forced override");
        check("R7 forced no flag", 32'(flags), 0);

        // R9 readback
        rd(A_MASK, v); check("R9 mask readback", 32'(v), 32'h85);
        rd(A_DATA, v); check("R9 data readback", 32'(v), 32'h01);

        // R8 disconnect and select gating
        b_disc = 8'h02; wr(A_DISC, b_disc);
        check_pins("R8 disconnect");
        set_sel(8'h83);
        check_pins("R8 masked pin without select");
        b_disc = 8'h00; wr(A_DISC, b_disc);
        check_pins("R8 reconnect");

        finish_run();
    end

endmodule